// File: doc/BRIEF.md
# Power-of-Two Clock Divider with Glitch-Free Output Gate

This block takes a fast input clock and produces a divided clock at one of four ratios (1, 2, 4 or 8), chosen by a 2-bit code from a configuration latch elsewhere on the chip. For the ratios 2, 4 and 8 a down-counter drives a registered output that is high for the first half of each period and low for the second. For the ratio 1 the input clock itself is passed through a clock gate.

An active-high enable turns the output on and off. Both a new enable and a new ratio code are sampled only at a period boundary, which is the input edge where the divided output would rise. The output is low during the cycle before that edge, so starting, stopping or changing the ratio never shortens a high or a low phase. The block has no data path and no handshake: every pin is a plain control or clock pin.

Top module: `clk_div_gate`

## Requirements
- R1: The ratio code maps non-monotonically to the divide ratio: 2'b00 selects 2, 2'b01 selects 4, 2'b10 selects 8 and 2'b11 selects 1 (pass-through).
- R2: For ratios 2, 4 and 8 the output changes only after rising input edges, is high for exactly ratio/2 input cycles starting at the boundary edge, and is then low for ratio/2 cycles.
- R3: The enable is sampled only at a period boundary. While the applied enable is low the output stays low. The first high phase after enabling has full width, and a high phase in progress when the enable drops completes before the output stays low.
- R4: A ratio code change is adopted only at the next period boundary. The period in progress finishes at the old ratio, and the new ratio applies from that boundary onward.
- R5: With ratio 1 every input edge is a boundary. The output equals the input clock ANDed with a gate value that a latch captures while the input clock is low. An enable sampled at edge k therefore first shows in the high phase that starts at edge k+1.
- R6: Synchronous active-high reset forces the output low, clears the applied enable and leaves the counter so that the first rising edge after reset is a period boundary. At that edge the ratio code and the enable are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Output enable, active high, sampled at period boundaries |
| ratio_i | input | 2 | Ratio code from the configuration latch (see R1) |
| clk_o | output | 1 | Divided, gated clock output |

## Verification
A counter that skips or repeats a count shows at clk_o within one divided period, as a high or low phase of the wrong length. An applied ratio or enable register that updates away from a boundary shows as a truncated phase in the same period. A fault in the ratio-1 gate latch shows one input cycle after an enable change, because the high phase that follows takes the wrong level. The bench samples clk_o in the middle of every high and every low input phase, so any of these faults shows at the first affected half-cycle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CODE_W  = 2;
  localparam int MAX_DIV = 8;
  localparam int CNT_W   = $clog2(MAX_DIV);
  localparam logic [CODE_W-1:0] CODE_BYPASS = 2'b11;
endpackage

// File: rtl/clkdiv_ratio_decode.sv
module clkdiv_ratio_decode
  import clkdiv_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W:0]    ratio_o
);
  // code 11 is the pass-through; the others select 2^(code+1)
  logic [CNT_W-1:0] shift;

  always_comb begin
    if (code_i == CODE_BYPASS) shift = '0;
    else                       shift = CNT_W'(code_i) + 1'b1;
    ratio_o = (CNT_W+1)'(1) << shift;
  end
endmodule

// File: rtl/clkdiv_phase_ctr.sv
module clkdiv_phase_ctr
  import clkdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [CNT_W-1:0] ld_last_i,
  input  logic [CNT_W-1:0] run_half_i,
  input  logic             en_new_i,
  input  logic             en_cur_i,
  output logic             wrap_o,
  output logic             out_q
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_dec;

  assign wrap_o  = (cnt_q == '0);
  assign cnt_dec = cnt_q - 1'b1;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (wrap_o) begin
      cnt_q <= ld_last_i;
      // ratio 1 loads zero: the register path stays idle
      out_q <= en_new_i & (ld_last_i != '0);
    end else begin
      cnt_q <= cnt_dec;
      out_q <= en_cur_i & (cnt_dec >= run_half_i);
    end
  end
endmodule

// File: rtl/clkdiv_clk_gate.sv
module clkdiv_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic gate_l;

  always_latch begin
    if (!clk_i) gate_l = en_i;
  end

  assign gclk_o = clk_i & gate_l;
endmodule

// File: rtl/clk_div_gate.sv
module clk_div_gate
  import clkdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] ratio_i,
  output logic              clk_o
);
  logic [CODE_W-1:0] act_q;
  logic              en_q;
  logic              wrap;
  logic              out_q;
  logic              gclk;
  logic [CNT_W:0]    ld_ratio;
  logic [CNT_W:0]    run_ratio;
  logic [CNT_W-1:0]  ld_last;
  logic [CNT_W-1:0]  run_half;
  logic              run_bypass;

  clkdiv_ratio_decode u_dec_ld  (.code_i(ratio_i), .ratio_o(ld_ratio));
  clkdiv_ratio_decode u_dec_run (.code_i(act_q),   .ratio_o(run_ratio));

  assign ld_last    = CNT_W'(ld_ratio - 1'b1);
  assign run_half   = CNT_W'(run_ratio >> 1);
  assign run_bypass = (run_ratio == (CNT_W+1)'(1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      act_q <= '0;
      en_q  <= 1'b0;
    end else if (wrap) begin
      act_q <= ratio_i;
      en_q  <= en_i;
    end
  end

  clkdiv_phase_ctr u_ctr (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .ld_last_i (ld_last),
    .run_half_i(run_half),
    .en_new_i  (en_i),
    .en_cur_i  (en_q),
    .wrap_o    (wrap),
    .out_q     (out_q)
  );

  clkdiv_clk_gate u_gate (
    .clk_i (clk_i),
    .en_i  (en_q),
    .gclk_o(gclk)
  );

  assign clk_o = run_bypass ? gclk : out_q;
endmodule

// File: rtl/clk_div_gate_chk.sv
module clk_div_gate_chk
  import clkdiv_pkg::*;
(
  input logic              clk_i,
  input logic              rst_i,
  input logic [CODE_W-1:0] act_q,
  input logic              en_q,
  input logic              wrap,
  input logic              out_q,
  input logic [CNT_W-1:0]  run_half
);
  logic [CNT_W:0] hi_len;

  always_ff @(posedge clk_i) begin
    if (rst_i)      hi_len <= '0;
    else if (out_q) hi_len <= hi_len + 1'b1;
    else            hi_len <= '0;
  end

  // R4
  ratio_at_boundary_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(act_q) |-> $past(wrap));

  // R3
  enable_when_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(en_q) |-> !$past(out_q));

  // R3
  disabled_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_q |-> !out_q);

  // R2
  rise_at_boundary_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(out_q) |-> $past(wrap));

  // R2
  high_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!out_q && hi_len != '0) |-> ((CNT_W+1)'(run_half) == hi_len));

  // R5
  bypass_reg_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (act_q == CODE_BYPASS) |-> !out_q);
endmodule

bind clk_div_gate clk_div_gate_chk u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .act_q   (act_q),
  .en_q    (en_q),
  .wrap    (wrap),
  .out_q   (out_q),
  .run_half(run_half)
);

// File: tb/clk_div_gate_tb.sv
`timescale 1ns/1ps
module clk_div_gate_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [1:0] ratio = 2'b00;
  logic       clk_o;

  int checks = 0;
  int fails  = 0;
  string tag = "R6";
  bit chk_on = 1'b0;

  // reference state
  int m_cnt = 0, m_r = 2, m_en = 0, m_out = 0, m_gate = 0;

  always #4 clk = ~clk;

  clk_div_gate u_dut (
    .clk_i(clk), .rst_i(rst), .en_i(en), .ratio_i(ratio), .clk_o(clk_o)
  );

  function automatic int ratio_of(input logic [1:0] c);
    case (c)
      2'b00:   return 2;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 1;
    endcase
  endfunction

  task automatic check(input int exp, input string where);
    checks++;
    if (clk_o !== exp[0]) begin
      fails++;
      $display("FAIL %s (%s) t=%0t: clk_o=%b expected=%0d", tag, where, $time, clk_o, exp);
    end
  endtask

  // reference model and comparison in both half-periods
  always begin
    @(posedge clk);
    m_gate = m_en;
    if (rst) begin
      m_cnt = 0; m_r = 2; m_en = 0; m_out = 0;
    end else if (m_cnt == 0) begin
      m_r   = ratio_of(ratio);
      m_en  = en ? 1 : 0;
      m_cnt = m_r - 1;
      m_out = (m_en == 1 && m_r > 1) ? 1 : 0;
    end else begin
      m_cnt = m_cnt - 1;
      m_out = (m_en == 1 && m_cnt >= m_r / 2) ? 1 : 0;
    end
    #2;
    if (chk_on) check((m_r == 1) ? m_gate : m_out, "high phase");
    @(negedge clk);
    #2;
    if (chk_on) check((m_r == 1) ? 0 : m_out, "low phase");
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    // R6: reset state, then first edge after release is a boundary
    run(2);
    chk_on = 1'b1;
    run(3);
    tag = "R6"; en = 1'b1; ratio = 2'b01;
    run(1); rst = 1'b0;
    run(12);
    // R1 / R2: each register-path ratio
    tag = "R1"; ratio = 2'b00; run(12);
    tag = "R2"; ratio = 2'b10; run(40);
    tag = "R1"; ratio = 2'b01; run(21);
    // R4: change code at several phases of a divide-by-8 period
    tag = "R4"; ratio = 2'b10; run(11);
    ratio = 2'b00; run(3);
    ratio = 2'b10; run(5);
    ratio = 2'b01; run(17);
    // R3: enable drops and returns at odd phases
    tag = "R3"; ratio = 2'b10; run(6);
    en = 1'b0; run(3);
    en = 1'b1; run(1);
    en = 1'b0; run(13);
    en = 1'b1; run(19);
    en = 1'b0; ratio = 2'b00; run(5);
    en = 1'b1; run(7);
    // R5: pass-through with enable toggles
    tag = "R5"; ratio = 2'b11; run(10);
    en = 1'b0; run(4);
    en = 1'b1; run(1);
    en = 1'b0; run(1);
    en = 1'b1; run(6);
    ratio = 2'b01; run(9);
    ratio = 2'b11; run(6);
    ratio = 2'b00; run(6);
    // R6: reset in mid-period
    tag = "R6"; ratio = 2'b10; run(13);
    rst = 1'b1; run(3);
    rst = 1'b0; ratio = 2'b11; run(6);
    ratio = 2'b01; run(12);
    chk_on = 1'b0;
    run(1);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule